// File: doc/BRIEF.md
# Instruction Fetch Line Buffer

This block sits between an in-order fetch stage and an instruction cache port. It holds a small fully associative set of cache lines so that several fetches to the same line share one memory read. It keeps two tables of equal depth. The miss table holds lines that have been requested from memory but are not yet consumed. The line buffer holds filled lines in recency order. Each entry is tagged by an address-space identifier and a line number, and each entry carries a count of fetch requests that are still waiting on it.

The fetch stage works in two steps. It first sends an initiate request. The reply says whether the fetch will be served from an already known line or whether it caused a new line read. Later the fetch stage sends a complete request, which returns the 32-bit instruction word. A squash request withdraws an earlier initiate. Squashes decrement the waiting counts and can cancel a miss-table entry. A line is evicted only when its waiting count is zero. The search for a victim runs from the least recently used line.

Request encodings on `req_op` are: 0 initiate, 1 complete, 2 squash. Code 3 is never accepted. Addresses are byte addresses. A line is 8 words of 32 bits, so address bits [4:2] select the word and bits [31:5] form the line number.

Top module: `ifetch_line_buf`

## Requirements
- R1: A lookup hits an entry only when both the address-space identifier and the line number match. A line held for one identifier is a miss for another identifier.
- R2: An initiate that hits the miss table is accepted. It increments that entry's count, issues no memory read, and replies with `rsp_buffered`=1.
- R3: An initiate that misses the miss table, while that table is not full, and hits the line buffer is accepted. It increments the line's count, issues no read, and replies with `rsp_buffered`=1.
- R4: An initiate that does not hit the miss table while all miss-table entries are allocated is refused (`req_ready`=0), even if the line buffer holds the line.
- R5: A true miss is accepted with `rsp_buffered`=0. The next cycle it raises `mem_rd_valid` with the line-aligned address and the lowest free miss-table index on `mem_rd_idx`. The new entry's count is 1.
- R6: A fill stores its line in the miss-table entry named by `fill_idx`. A fill for an entry freed by a squash is dropped, so a later initiate to that line is again a miss.
- R7: A complete with `req_from_buf`=1 is refused until the line is in the line buffer. Once accepted, it returns word (address bits [4:2]) of the line, decrements the line's count, and makes the line most recently used.
- R8: A complete with `req_from_buf`=0 is refused until the fill has arrived. If the line buffer is full, the least recently used line with a zero count is evicted; if no line has a zero count, the complete is refused.
- R9: A completed miss returns its word, decrements the count, leaves the miss table, and enters the line buffer as most recently used.
- R10: A squash decrements a matching line-buffer entry. If no line-buffer entry matches, it decrements a matching miss-table entry and frees that entry when its count reaches zero.
- R11: Decrementing a zero count leaves the count at zero and sets the sticky `err_underflow` output.
- R12: While `rsp_ready` is low, the reply holds `rsp_valid` and its fields stable and new initiates or completes are refused. While `mem_rd_ready` is low, a line read holds its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_op | input | 2 | 0 initiate, 1 complete, 2 squash |
| req_asid | input | 4 | Address-space identifier |
| req_addr | input | 32 | Fetch byte address |
| req_from_buf | input | 1 | Complete: the fetch was served from a known line |
| rsp_valid | output | 1 | Reply present |
| rsp_ready | input | 1 | Reply taken |
| rsp_buffered | output | 1 | Initiate reply: 1 when served from a known line |
| rsp_word | output | 32 | Complete reply: instruction word |
| mem_rd_valid | output | 1 | Line read request present |
| mem_rd_ready | input | 1 | Line read taken |
| mem_rd_addr | output | 32 | Line-aligned read address |
| mem_rd_idx | output | 2 | Miss-table index that the fill must carry |
| fill_valid | input | 1 | Fill line present |
| fill_ready | output | 1 | Always 1 |
| fill_idx | input | 2 | Miss-table index of the fill |
| fill_data | input | 256 | Line data, word 0 in bits [31:0] |
| err_underflow | output | 1 | Sticky count-underflow flag |

## Verification
The `req_ready` output is combinational in the current state and the request inputs. The bench therefore reads it just after driving a request at the falling edge. Replies and line reads are registered, so they are due one clock after acceptance. The bench samples them at the next falling edge. A fill becomes visible to the request path one clock after it is presented, and the bench always sends the dependent complete in a later cycle. Stall cases are checked as a refused handshake in the same cycle. Eviction choices are checked through whether a later initiate hits or misses.

// File: rtl/flb_pkg.sv
package flb_pkg;
    typedef enum logic [1:0] {
        OP_INIT     = 2'd0,
        OP_COMPLETE = 2'd1,
        OP_SQUASH   = 2'd2
    } flb_op_e;
endpackage

// File: rtl/flb_first.sv
// Lowest set bit of a vector: found flag and index.
module flb_first #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/flb_match.sv
// Associative compare of a key against N tagged entries.
module flb_match #(
    parameter int N     = 4,
    parameter int KEY_W = 31,
    parameter int IW    = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]       vld,
    input  logic [N*KEY_W-1:0] keys,
    input  logic [KEY_W-1:0]   key,
    output logic               hit,
    output logic [IW-1:0]      idx
);
    logic [N-1:0] eq;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign eq[g] = vld[g] && (keys[g*KEY_W +: KEY_W] == key);
    end

    flb_first #(.N(N), .IW(IW)) u_enc (
        .vec  (eq),
        .found(hit),
        .idx  (idx)
    );
endmodule

// File: rtl/flb_word_sel.sv
// Pick one word out of a line.
module flb_word_sel #(
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 8,
    parameter int SEL_W      = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1
) (
    input  logic [WORD_W*LINE_WORDS-1:0] line,
    input  logic [SEL_W-1:0]             sel,
    output logic [WORD_W-1:0]            word
);
    logic [WORD_W-1:0] words [LINE_WORDS];

    for (genvar g = 0; g < LINE_WORDS; g++) begin : g_split
        assign words[g] = line[g*WORD_W +: WORD_W];
    end

    assign word = words[sel];
endmodule

// File: rtl/ifetch_line_buf.sv
module ifetch_line_buf #(
    parameter int ASID_W     = 4,
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 8,
    parameter int DEPTH      = 4,
    parameter int CNT_W      = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic [1:0]                   req_op,
    input  logic [ASID_W-1:0]            req_asid,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic                         req_from_buf,
    output logic                         rsp_valid,
    input  logic                         rsp_ready,
    output logic                         rsp_buffered,
    output logic [WORD_W-1:0]            rsp_word,
    output logic                         mem_rd_valid,
    input  logic                         mem_rd_ready,
    output logic [ADDR_W-1:0]            mem_rd_addr,
    output logic [$clog2(DEPTH)-1:0]     mem_rd_idx,
    input  logic                         fill_valid,
    output logic                         fill_ready,
    input  logic [$clog2(DEPTH)-1:0]     fill_idx,
    input  logic [WORD_W*LINE_WORDS-1:0] fill_data,
    output logic                         err_underflow
);
    import flb_pkg::*;

    localparam int IDX_W     = $clog2(DEPTH);
    localparam int NW        = $clog2(DEPTH + 1);
    localparam int BYTE_W    = $clog2(WORD_W / 8);
    localparam int SEL_W     = $clog2(LINE_WORDS);
    localparam int LOFF      = BYTE_W + SEL_W;
    localparam int TAG_W     = ADDR_W - LOFF;
    localparam int KEY_W     = ASID_W + TAG_W;
    localparam int LINE_BITS = WORD_W * LINE_WORDS;

    typedef struct packed {
        logic [ASID_W-1:0]    asid;
        logic [TAG_W-1:0]     tag;
        logic [CNT_W-1:0]     cnt;
        logic [LINE_BITS-1:0] data;
    } line_t;

    typedef struct packed {
        line_t [DEPTH-1:0] lb;        // index 0 = least recently used
        logic  [NW-1:0]    lb_n;
        line_t [DEPTH-1:0] pd;
        logic  [DEPTH-1:0] pd_alloc;
        logic  [DEPTH-1:0] pd_fill;
        logic  [DEPTH-1:0] pd_infl;
        logic              mem_v;
        logic [TAG_W-1:0]  mem_tag;
        logic [IDX_W-1:0]  mem_idx;
        logic              rsp_v;
        logic              rsp_buf;
        logic [WORD_W-1:0] rsp_word;
        logic              err;
    } state_t;

    state_t q, d;

    // ---- key and flag vectors for the lookup units ----
    logic [DEPTH-1:0]       lb_vld, lb_zero, pd_free;
    logic [DEPTH*KEY_W-1:0] lb_keys, pd_keys;
    logic [KEY_W-1:0]       req_key;
    logic [TAG_W-1:0]       req_tag;

    assign req_tag = req_addr[ADDR_W-1:LOFF];
    assign req_key = {req_asid, req_tag};

    always_comb begin
        for (int j = 0; j < DEPTH; j++) begin
            lb_vld[j]                  = (j < int'(q.lb_n));
            lb_zero[j]                 = lb_vld[j] && (q.lb[j].cnt == '0);
            pd_free[j]                 = !q.pd_alloc[j] && !q.pd_infl[j];
            lb_keys[j*KEY_W +: KEY_W]  = {q.lb[j].asid, q.lb[j].tag};
            pd_keys[j*KEY_W +: KEY_W]  = {q.pd[j].asid, q.pd[j].tag};
        end
    end

    logic             lb_hit, pd_hit, free_found, vic_found;
    logic [IDX_W-1:0] lb_idx, pd_idx, free_idx, vic_idx;

    flb_match #(.N(DEPTH), .KEY_W(KEY_W), .IW(IDX_W)) u_lb_match (
        .vld(lb_vld), .keys(lb_keys), .key(req_key), .hit(lb_hit), .idx(lb_idx)
    );

    flb_match #(.N(DEPTH), .KEY_W(KEY_W), .IW(IDX_W)) u_pd_match (
        .vld(q.pd_alloc), .keys(pd_keys), .key(req_key), .hit(pd_hit), .idx(pd_idx)
    );

    flb_first #(.N(DEPTH), .IW(IDX_W)) u_free (
        .vec(pd_free), .found(free_found), .idx(free_idx)
    );

    flb_first #(.N(DEPTH), .IW(IDX_W)) u_victim (
        .vec(lb_zero), .found(vic_found), .idx(vic_idx)
    );

    logic [LINE_BITS-1:0] sel_line;
    logic [WORD_W-1:0]    sel_word;

    assign sel_line = req_from_buf ? q.lb[lb_idx].data : q.pd[pd_idx].data;

    flb_word_sel #(.WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS), .SEL_W(SEL_W)) u_word (
        .line(sel_line), .sel(req_addr[BYTE_W +: SEL_W]), .word(sel_word)
    );

    // ---- next-state logic ----
    flb_op_e op;
    logic    lb_full, pd_full, rsp_free, rd_free, can_go, fire;
    line_t   moved;

    assign op = flb_op_e'(req_op);

    always_comb begin
        d        = q;
        moved    = '0;
        lb_full  = (q.lb_n == NW'(DEPTH));
        pd_full  = &q.pd_alloc;
        rsp_free = !q.rsp_v || rsp_ready;
        rd_free  = !q.mem_v || mem_rd_ready;

        unique case (op)
            OP_INIT:     can_go = rsp_free && (pd_hit || (!pd_full && lb_hit) ||
                                  (!pd_full && free_found && rd_free));
            OP_COMPLETE: can_go = rsp_free && (req_from_buf ? lb_hit :
                                  (pd_hit && q.pd_fill[pd_idx] && (!lb_full || vic_found)));
            OP_SQUASH:   can_go = 1'b1;
            default:     can_go = 1'b0;
        endcase
        fire = req_valid && can_go;

        if (q.mem_v && mem_rd_ready) d.mem_v = 1'b0;
        if (q.rsp_v && rsp_ready)    d.rsp_v = 1'b0;

        // fill: only a still-allocated entry keeps the data
        if (fill_valid) begin
            d.pd_infl[fill_idx] = 1'b0;
            if (q.pd_alloc[fill_idx]) begin
                d.pd[fill_idx].data    = fill_data;
                d.pd_fill[fill_idx]    = 1'b1;
            end
        end

        if (fire) begin
            unique case (op)
                OP_INIT: begin
                    d.rsp_v    = 1'b1;
                    d.rsp_word = '0;
                    if (pd_hit) begin
                        d.rsp_buf = 1'b1;
                        if (q.pd[pd_idx].cnt != '1) d.pd[pd_idx].cnt = q.pd[pd_idx].cnt + 1'b1;
                    end else if (lb_hit) begin
                        d.rsp_buf = 1'b1;
                        if (q.lb[lb_idx].cnt != '1) d.lb[lb_idx].cnt = q.lb[lb_idx].cnt + 1'b1;
                    end else begin
                        d.rsp_buf            = 1'b0;
                        d.pd[free_idx].asid  = req_asid;
                        d.pd[free_idx].tag   = req_tag;
                        d.pd[free_idx].cnt   = CNT_W'(1);
                        d.pd[free_idx].data  = '0;
                        d.pd_alloc[free_idx] = 1'b1;
                        d.pd_fill[free_idx]  = 1'b0;
                        d.pd_infl[free_idx]  = 1'b1;
                        d.mem_v              = 1'b1;
                        d.mem_tag            = req_tag;
                        d.mem_idx            = free_idx;
                    end
                end
                OP_COMPLETE: begin
                    d.rsp_v    = 1'b1;
                    d.rsp_buf  = req_from_buf;
                    d.rsp_word = sel_word;
                    if (req_from_buf) begin
                        moved = q.lb[lb_idx];
                        if (moved.cnt == '0) d.err = 1'b1;
                        else                 moved.cnt = moved.cnt - 1'b1;
                        for (int j = 0; j < DEPTH - 1; j++) begin
                            if (j >= int'(lb_idx) && j < int'(q.lb_n) - 1) d.lb[j] = q.lb[j+1];
                        end
                        d.lb[IDX_W'(q.lb_n - 1'b1)] = moved;
                    end else begin
                        moved = q.pd[pd_idx];
                        if (moved.cnt == '0) d.err = 1'b1;
                        else                 moved.cnt = moved.cnt - 1'b1;
                        d.pd_alloc[pd_idx] = 1'b0;
                        d.pd_fill[pd_idx]  = 1'b0;
                        if (lb_full) begin
                            for (int j = 0; j < DEPTH - 1; j++) begin
                                if (j >= int'(vic_idx)) d.lb[j] = q.lb[j+1];
                            end
                            d.lb[DEPTH-1] = moved;
                        end else begin
                            d.lb[IDX_W'(q.lb_n)] = moved;
                            d.lb_n               = q.lb_n + 1'b1;
                        end
                    end
                end
                OP_SQUASH: begin
                    if (lb_hit) begin
                        if (q.lb[lb_idx].cnt == '0) d.err = 1'b1;
                        else d.lb[lb_idx].cnt = q.lb[lb_idx].cnt - 1'b1;
                    end else if (pd_hit) begin
                        if (q.pd[pd_idx].cnt == '0) d.err = 1'b1;
                        else d.pd[pd_idx].cnt = q.pd[pd_idx].cnt - 1'b1;
                        if (q.pd[pd_idx].cnt <= CNT_W'(1)) begin
                            d.pd_alloc[pd_idx] = 1'b0;
                            d.pd_fill[pd_idx]  = 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready     = can_go;
    assign rsp_valid     = q.rsp_v;
    assign rsp_buffered  = q.rsp_buf;
    assign rsp_word      = q.rsp_word;
    assign mem_rd_valid  = q.mem_v;
    assign mem_rd_addr   = {q.mem_tag, {LOFF{1'b0}}};
    assign mem_rd_idx    = q.mem_idx;
    assign fill_ready    = 1'b1;
    assign err_underflow = q.err;

    // ---- assertions ----
    assert_rsp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_word) && $stable(rsp_buffered));

    assert_rd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

    assert_full_refuse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_op == 2'd0 && $countones(q.pd_alloc) == DEPTH && !pd_hit |-> !req_ready);

    assert_pend_hit_buffered_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_op == 2'd0 && pd_hit |=> rsp_valid && rsp_buffered);

    assert_fill_inflight_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> q.pd_infl[fill_idx]);

    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err_underflow |=> err_underflow);

    assert_lb_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q.lb_n <= NW'(DEPTH));
endmodule

// File: tb/ifetch_line_buf_tb.sv
`timescale 1ns/1ps
module ifetch_line_buf_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0, req_ready, req_from_buf = 1'b0;
    logic [1:0]   req_op = 2'd0;
    logic [3:0]   req_asid = '0;
    logic [31:0]  req_addr = '0;
    logic         rsp_valid, rsp_ready = 1'b1, rsp_buffered;
    logic [31:0]  rsp_word;
    logic         mem_rd_valid, mem_rd_ready = 1'b1;
    logic [31:0]  mem_rd_addr;
    logic [1:0]   mem_rd_idx;
    logic         fill_valid = 1'b0, fill_ready;
    logic [1:0]   fill_idx = '0;
    logic [255:0] fill_data = '0;
    logic         err_underflow;

    int checks = 0;
    int errors = 0;

    localparam logic [31:0] LA = 32'h1000, LB = 32'h2000, LC = 32'h3000,
                            LD = 32'h4000, LE = 32'h5000;

    always #2 clk = ~clk;

    ifetch_line_buf u_dut (.*);

    function automatic logic [31:0] wexp(input logic [31:0] la, input int k);
        return (la | 32'(k << 2)) ^ 32'hC3C3_0000;
    endfunction

    function automatic logic [255:0] lexp(input logic [31:0] la);
        logic [255:0] v;
        for (int k = 0; k < 8; k++) v[k*32 +: 32] = wexp(la, k);
        return v;
    endfunction

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // one handshake attempt; returns with registered outputs visible
    task automatic send(input logic [1:0] op, input logic [3:0] asid, input logic [31:0] addr,
                        input logic fb, output logic acc);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_asid = asid; req_addr = addr; req_from_buf = fb;
        #1 acc = req_ready;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic fill(input logic [1:0] idx, input logic [255:0] data);
        @(negedge clk);
        fill_valid = 1'b1; fill_idx = idx; fill_data = data;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic init_hit(input string rq, input logic [3:0] asid, input logic [31:0] addr);
        logic a;
        send(2'd0, asid, addr, 1'b0, a);
        chk({rq, " hit accepted"}, 32'(a), 1);
        chk({rq, " buffered"}, 32'(rsp_buffered), 1);
        chk({rq, " no read"}, 32'(mem_rd_valid), 0);
    endtask

    task automatic init_miss(input string rq, input logic [3:0] asid, input logic [31:0] addr,
                             input logic [1:0] idx);
        logic a;
        send(2'd0, asid, addr, 1'b0, a);
        chk({rq, " miss accepted"}, 32'(a), 1);
        chk({rq, " not buffered"}, 32'(rsp_buffered), 0);
        chk({rq, " read valid"}, 32'(mem_rd_valid), 1);
        chk({rq, " read addr"}, mem_rd_addr, addr & 32'hFFFF_FFE0);
        chk({rq, " read idx"}, 32'(mem_rd_idx), 32'(idx));
    endtask

    task automatic complete(input string rq, input logic [3:0] asid, input logic [31:0] addr,
                            input logic fb, input logic [31:0] exp);
        logic a;
        send(2'd1, asid, addr, fb, a);
        chk({rq, " complete accepted"}, 32'(a), 1);
        chk({rq, " word"}, rsp_word, exp);
    endtask

    task automatic refused(input string rq, input logic [1:0] op, input logic [3:0] asid,
                           input logic [31:0] addr, input logic fb);
        logic a;
        send(op, asid, addr, fb, a);
        chk({rq, " refused"}, 32'(a), 0);
    endtask

    task automatic squash(input logic [3:0] asid, input logic [31:0] addr);
        logic a;
        send(2'd2, asid, addr, 1'b0, a);
        chk("R10 squash accepted", 32'(a), 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R12 reset rsp_valid", 32'(rsp_valid), 0);
        chk("R5 reset mem_rd_valid", 32'(mem_rd_valid), 0);
        chk("R11 reset err", 32'(err_underflow), 0);
        rst_n = 1'b1;

        init_miss("R5", 4'd1, LA + 32'h0C, 2'd0);
        init_hit ("R2", 4'd1, LA + 32'h10);
        init_miss("R1", 4'd2, LA, 2'd1);
        refused  ("R7 before fill", 2'd1, 4'd1, LA + 32'h10, 1'b1);
        refused  ("R8 before fill", 2'd1, 4'd1, LA + 32'h0C, 1'b0);
        fill(2'd0, lexp(LA));
        complete("R9", 4'd1, LA + 32'h0C, 1'b0, wexp(LA, 3));
        complete("R7", 4'd1, LA + 32'h10, 1'b1, wexp(LA, 4));

        // squash frees the asid-2 miss; its late fill is dropped
        squash(4'd2, LA);
        fill(2'd1, ~lexp(LA));
        init_miss("R6", 4'd2, LA, 2'd0);
        fill(2'd0, lexp(LA));
        complete("R6", 4'd2, LA, 1'b0, wexp(LA, 0));

        // every word offset through the line buffer
        for (int k = 0; k < 8; k++) begin
            init_hit("R3", 4'd1, LA + 32'(k * 4));
            complete("R7 sweep", 4'd1, LA + 32'(k * 4), 1'b1, wexp(LA, k));
        end

        // fill the miss table
        init_miss("R5 B", 4'd1, LB, 2'd0);
        init_miss("R5 C", 4'd1, LC, 2'd1);
        init_miss("R5 D", 4'd1, LD, 2'd2);
        init_miss("R5 E", 4'd1, LE, 2'd3);
        refused("R4 full", 2'd0, 4'd1, LA, 1'b0);
        init_hit("R2 full", 4'd1, LB + 32'h4);
        fill(2'd0, lexp(LB)); fill(2'd1, lexp(LC));
        fill(2'd2, lexp(LD)); fill(2'd3, lexp(LE));
        complete("R9 C", 4'd1, LC + 32'h8, 1'b0, wexp(LC, 2));
        complete("R9 D", 4'd1, LD, 1'b0, wexp(LD, 0));
        complete("R8 E", 4'd1, LE + 32'h1C, 1'b0, wexp(LE, 7));
        // LRU zero-count line (asid 2) was evicted, asid 1 kept
        init_hit ("R8 kept", 4'd1, LA);
        init_miss("R8 evicted", 4'd2, LA, 2'd1);
        init_hit("R3 C", 4'd1, LC);
        init_hit("R3 D", 4'd1, LD);
        init_hit("R3 E", 4'd1, LE);
        refused("R8 no victim", 2'd1, 4'd1, LB, 1'b0);
        squash(4'd1, LD);
        complete("R8 B", 4'd1, LB, 1'b0, wexp(LB, 0));
        init_miss("R10 D gone", 4'd1, LD, 2'd0);
        complete("R7 B", 4'd1, LB + 32'h4, 1'b1, wexp(LB, 1));

        // underflow
        squash(4'd1, LA);
        chk("R11 no err yet", 32'(err_underflow), 0);
        squash(4'd1, LA);
        chk("R11 err set", 32'(err_underflow), 1);

        // reply backpressure
        rsp_ready = 1'b0;
        init_hit("R12 held", 4'd1, LC + 32'h8);
        @(negedge clk);
        chk("R12 still valid", 32'(rsp_valid), 1);
        chk("R12 still buffered", 32'(rsp_buffered), 1);
        refused("R12 blocked", 2'd0, 4'd1, LC, 1'b0);
        rsp_ready = 1'b1;
        @(negedge clk);
        chk("R12 released", 32'(rsp_valid), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule